// File: doc/BRIEF.md
# Prescaled Reloadable Wake-Up Timer

This block is a small always-on timer that keeps counting while the rest of the chip sleeps. A 7-bit prescaler steps on every timer clock and feeds a 16-bit down counter, so the two together form a 23-bit chain. When both stages sit at zero, the counter reloads itself from a software-written value and raises a sticky flag. The flag, when enabled, drives an interrupt/wake line that can bring the rest of the chip back up.

The timer clock is either the CPU clock or the crystal clock. The crystal path is refused whenever the crystal is already the CPU clock, and in that case the CPU clock is used. Software reaches the block through a simple write port (reload value or control word) and a flag-clear strobe. Only the power-on reset restores the defaults. While the ordinary reset is held, the timer keeps running but ignores writes and clears.

Top module: `wake_timer`

## Requirements
- R1: After a power-on reset, `tmr_count` reads 16'hFFFF, `tmr_flag` and `irq_wake` are 0, `clk_src_xtal` is 0, and the timer stays stopped because the control word defaults to all zeros.
- R2: A reload write (`wr_sel`=0) copies `wr_data` into the reload register and into the counter at the same edge, and restarts the prescaler at 127. While running, the counter then steps down once every 128 timer clocks.
- R3: When the counter and prescaler are both zero at a running edge, the counter reloads and `tmr_flag` is set. The flag therefore first rises (R+1)*128 edges after a reload write of R, and again every (R+1)*128 edges after that.
- R4: `tmr_flag` stays set until `flag_clr` is high at an edge. If setting and clearing fall on the same edge, the flag stays set.
- R5: `irq_wake` is high exactly when `tmr_flag` is set and the interrupt-enable bit (control bit 1) is set.
- R6: With the run bit (control bit 0) clear, the counter and prescaler hold their values and no flag is raised.
- R7: Control bit 2 selects the crystal clock. The crystal clock is used only when `xtal_is_cpu` is low; otherwise the CPU clock runs the timer. `clk_src_xtal` reports the clock that is in effect.
- R8: While `rst_n` is low, register writes and flag clears are ignored. Counting, the flag and all settings carry on unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpu_clk | input | 1 | CPU clock |
| xtal_clk | input | 1 | Crystal oscillator clock |
| xtal_is_cpu | input | 1 | High when the crystal is currently the CPU clock |
| por_n | input | 1 | Power-on reset, active low, synchronous to the timer clock |
| rst_n | input | 1 | Ordinary reset, active low; only blocks software access |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = reload value, 1 = control word |
| wr_data | input | 16 | Write data; control uses bits [2:0] = {use_xtal, irq_en, run} |
| flag_clr | input | 1 | Clears the terminal-count flag |
| tmr_count | output | 16 | Current down-counter value |
| tmr_flag | output | 1 | Sticky terminal-count flag |
| irq_wake | output | 1 | Interrupt / wake request |
| clk_src_xtal | output | 1 | High when the crystal clock drives the timer |

## Verification
Every result is registered, so a write, a clear or a count step shows on the outputs after the very edge that samples it. The one exception is `irq_wake`, which is a plain AND of two registers and shows after the edge that updates either of them. A flag after a reload of R therefore lands on edge (R+1)*128, counted from the write edge. The bench drives inputs on falling edges and advances by counted rising edges, checking each output at the next falling edge: one count short of the due edge to see the old value, and on it to see the new one. The crystal-rate checks instead measure the time between two flag rises, which must equal 128 periods of the clock in effect.

// File: rtl/wkt_pkg.sv
// Shared types of the wake-up timer: control word layout and register select.
package wkt_pkg;
    // Control word, bit 0 = run, bit 1 = irq_en, bit 2 = use_xtal.
    typedef struct packed {
        logic use_xtal;
        logic irq_en;
        logic run;
    } wkt_ctrl_t;

    localparam int CTRL_W = $bits(wkt_ctrl_t);

    typedef enum logic {
        SEL_RELOAD = 1'b0,
        SEL_CTRL   = 1'b1
    } wkt_reg_e;
endpackage

// File: rtl/wkt_clk_sel.sv
// Timer clock selection. Picks the crystal only if asked and only if the
// crystal is not already the CPU clock. Assumes the caller switches the
// select while both clocks are low; glitch-free switching is not provided.
module wkt_clk_sel (
    input  logic cpu_clk,
    input  logic xtal_clk,
    input  logic use_xtal,
    input  logic xtal_is_cpu,
    output logic tclk,
    output logic src_xtal
);
    // Effective source: crystal refused when it already feeds the CPU.
    assign src_xtal = use_xtal & ~xtal_is_cpu;
    // Plain clock multiplexer.
    assign tclk = src_xtal ? xtal_clk : cpu_clk;
endmodule

// File: rtl/wkt_regs.sv
// Software-visible settings: reload value and control word. Writes are
// accepted only outside ordinary reset; power-on reset alone sets defaults.
module wkt_regs
    import wkt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             tclk,
    input  logic             por_n,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] reload_q,
    output wkt_ctrl_t        ctrl_q,
    output logic             load
);
    logic wr_ok;

    // Accepted write: strobe high and not held in ordinary reset.
    assign wr_ok = wr_en & rst_n;
    // Reload write also restarts the counting chain.
    assign load  = wr_ok & (wkt_reg_e'(wr_sel) == SEL_RELOAD);

    // Register update; only power-on reset restores defaults.
    always_ff @(posedge tclk) begin
        if (!por_n) begin
            reload_q <= '1;
            ctrl_q   <= '0;
        end else if (wr_ok) begin
            if (wkt_reg_e'(wr_sel) == SEL_RELOAD) reload_q <= wr_data;
            else                                  ctrl_q   <= wkt_ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end

    // R8
    regs_hold_in_reset_chk: assert property (@(posedge tclk) disable iff (!por_n)
        !rst_n |=> ($stable(reload_q) && $stable(ctrl_q)));
endmodule

// File: rtl/wkt_count.sv
// Prescaler plus reloadable down counter. The prescaler steps every running
// clock; the counter steps when the prescaler wraps. Both at zero on a
// running edge is the terminal event: the counter reloads and term pulses.
module wkt_count #(
    parameter int PRE_W = 7,
    parameter int CNT_W = 16
) (
    input  logic             tclk,
    input  logic             por_n,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt_q,
    output logic             term
);
    localparam logic [PRE_W-1:0] PRE_TOP = '1;

    logic [PRE_W-1:0] pre_q;
    logic             pre_zero;
    logic             cnt_zero;

    // Stage-zero detection for both parts of the chain.
    assign pre_zero = (pre_q == '0);
    assign cnt_zero = (cnt_q == '0);
    // Terminal event; a simultaneous load takes precedence.
    assign term     = run & ~load & pre_zero & cnt_zero;

    // Chain update: load first, then running decrement with wrap/reload.
    always_ff @(posedge tclk) begin
        if (!por_n) begin
            pre_q <= PRE_TOP;
            cnt_q <= '1;
        end else if (load) begin
            pre_q <= PRE_TOP;
            cnt_q <= load_val;
        end else if (run) begin
            pre_q <= pre_q - 1'b1;
            if (pre_zero) cnt_q <= cnt_zero ? reload : cnt_q - 1'b1;
        end
    end

    // R2
    load_sets_chain_chk: assert property (@(posedge tclk) disable iff (!por_n)
        load |=> (cnt_q == $past(load_val) && pre_q == PRE_TOP));
    // R2
    step_on_wrap_only_chk: assert property (@(posedge tclk) disable iff (!por_n)
        (!load && !pre_zero) |=> $stable(cnt_q));
    // R3
    reload_on_term_chk: assert property (@(posedge tclk) disable iff (!por_n)
        term |=> (cnt_q == $past(reload)));
    // R6
    hold_when_stopped_chk: assert property (@(posedge tclk) disable iff (!por_n)
        (!run && !load) |=> ($stable(cnt_q) && $stable(pre_q)));
endmodule

// File: rtl/wkt_flag.sv
// Sticky terminal-count flag and interrupt/wake gating. Set has priority
// over clear; clear is assumed already gated by the ordinary reset.
module wkt_flag (
    input  logic tclk,
    input  logic por_n,
    input  logic set,
    input  logic clr,
    input  logic irq_en,
    output logic flag_q,
    output logic irq
);
    // Flag register with set-over-clear priority.
    always_ff @(posedge tclk) begin
        if (!por_n)   flag_q <= 1'b0;
        else if (set) flag_q <= 1'b1;
        else if (clr) flag_q <= 1'b0;
    end

    // Interrupt / wake request.
    assign irq = flag_q & irq_en;

    // R4
    flag_sticky_chk: assert property (@(posedge tclk) disable iff (!por_n)
        (flag_q && !clr) |=> flag_q);
    // R4
    set_beats_clear_chk: assert property (@(posedge tclk) disable iff (!por_n)
        set |=> flag_q);
endmodule

// File: rtl/wake_timer.sv
// Top of the wake-up timer: clock select, registers, counting chain and
// flag. Everything runs on the selected timer clock, including the write
// port; software is assumed to write only while that clock runs.
module wake_timer
    import wkt_pkg::*;
#(
    parameter int PRE_W = 7,
    parameter int CNT_W = 16
) (
    input  logic             cpu_clk,
    input  logic             xtal_clk,
    input  logic             xtal_is_cpu,
    input  logic             por_n,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] tmr_count,
    output logic             tmr_flag,
    output logic             irq_wake,
    output logic             clk_src_xtal
);
    logic             tclk;
    logic [CNT_W-1:0] reload_q;
    wkt_ctrl_t        ctrl_q;
    logic             load;
    logic             term;
    logic             clr_ok;

    // Flag clears are ignored during ordinary reset.
    assign clr_ok = flag_clr & rst_n;

    wkt_clk_sel u_sel (
        .cpu_clk     (cpu_clk),
        .xtal_clk    (xtal_clk),
        .use_xtal    (ctrl_q.use_xtal),
        .xtal_is_cpu (xtal_is_cpu),
        .tclk        (tclk),
        .src_xtal    (clk_src_xtal)
    );

    wkt_regs #(.CNT_W(CNT_W)) u_regs (
        .tclk     (tclk),
        .por_n    (por_n),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .reload_q (reload_q),
        .ctrl_q   (ctrl_q),
        .load     (load)
    );

    wkt_count #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_count (
        .tclk     (tclk),
        .por_n    (por_n),
        .run      (ctrl_q.run),
        .load     (load),
        .load_val (wr_data),
        .reload   (reload_q),
        .cnt_q    (tmr_count),
        .term     (term)
    );

    wkt_flag u_flag (
        .tclk   (tclk),
        .por_n  (por_n),
        .set    (term),
        .clr    (clr_ok),
        .irq_en (ctrl_q.irq_en),
        .flag_q (tmr_flag),
        .irq    (irq_wake)
    );

    // R5
    irq_needs_flag_chk: assert property (@(posedge tclk) disable iff (!por_n)
        irq_wake |-> tmr_flag);
    // R7
    xtal_refused_chk: assert property (@(posedge tclk) disable iff (!por_n)
        xtal_is_cpu |-> !clk_src_xtal);
endmodule

// File: tb/wake_timer_tb.sv
`timescale 1ns/1ps
module wake_timer_tb;
    logic        cpu_clk = 1'b0;
    logic        xtal_clk = 1'b0;
    logic        xtal_is_cpu = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_n = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic        flag_clr = 1'b0;
    logic [15:0] tmr_count;
    logic        tmr_flag;
    logic        irq_wake;
    logic        clk_src_xtal;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 cpu_clk = ~cpu_clk;   // 200 MHz
    always #10  xtal_clk = ~xtal_clk; // 50 MHz

    wake_timer u_dut (
        .cpu_clk(cpu_clk), .xtal_clk(xtal_clk), .xtal_is_cpu(xtal_is_cpu),
        .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .flag_clr(flag_clr), .tmr_count(tmr_count),
        .tmr_flag(tmr_flag), .irq_wake(irq_wake), .clk_src_xtal(clk_src_xtal)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // n rising edges, then settle on the next falling edge
    task automatic step(input int n);
        repeat (n) @(posedge cpu_clk);
        @(negedge cpu_clk);
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1;
        step(1);
        flag_clr = 1'b0;
    endtask

    task automatic t_reset();
        step(3);
        por_n = 1'b1;
        chk("R1 count", tmr_count, 16'hFFFF);
        chk("R1 flag", tmr_flag, 0);
        chk("R1 irq", irq_wake, 0);
        chk("R1 src", clk_src_xtal, 0);
        step(200);
        chk("R1 stopped by default", tmr_count, 16'hFFFF);
    endtask

    task automatic t_prescale();
        wr(1'b1, 16'h0001);
        wr(1'b0, 16'd3);
        chk("R2 loaded", tmr_count, 3);
        step(127);
        chk("R2 before wrap", tmr_count, 3);
        step(1);
        chk("R2 first step", tmr_count, 2);
        step(128);
        chk("R2 second step", tmr_count, 1);
    endtask

    task automatic t_terminal();
        wr(1'b0, 16'd1);
        step(255);
        chk("R3 flag not yet", tmr_flag, 0);
        step(1);
        chk("R3 flag set", tmr_flag, 1);
        chk("R3 reloaded", tmr_count, 1);
        pulse_clr();
        chk("R4 cleared", tmr_flag, 0);
        step(254);
        chk("R3 period not yet", tmr_flag, 0);
        step(1);
        chk("R3 repeat set", tmr_flag, 1);
    endtask

    task automatic t_set_wins();
        pulse_clr();
        chk("R4 cleared again", tmr_flag, 0);
        step(254);
        flag_clr = 1'b1;
        step(1);
        chk("R4 set wins over clear", tmr_flag, 1);
        step(1);
        chk("R4 clear next edge", tmr_flag, 0);
        flag_clr = 1'b0;
    endtask

    task automatic t_irq();
        wr(1'b0, 16'd0);
        step(127);
        chk("R5 flag pending", tmr_flag, 0);
        step(1);
        chk("R5 flag set", tmr_flag, 1);
        chk("R5 irq masked", irq_wake, 0);
        wr(1'b1, 16'h0003);
        chk("R5 irq enabled", irq_wake, 1);
        pulse_clr();
        chk("R5 irq drops with flag", irq_wake, 0);
    endtask

    task automatic t_hold();
        int c;
        wr(1'b1, 16'h0000);
        c = tmr_count;
        wr(1'b0, 16'd7);
        chk("R6 load while stopped", tmr_count, 7);
        step(300);
        chk("R6 count held", tmr_count, 7);
        chk("R6 no flag", tmr_flag, 0);
        if (c < 0) $display("unreachable");
    endtask

    task automatic t_ordinary_reset();
        wr(1'b1, 16'h0003);
        wr(1'b0, 16'd0);
        step(128);
        chk("R8 flag before reset", tmr_flag, 1);
        rst_n = 1'b0;
        pulse_clr();
        chk("R8 clear ignored", tmr_flag, 1);
        wr(1'b0, 16'd9);
        chk("R8 reload write ignored", tmr_count, 0);
        wr(1'b1, 16'h0000);
        chk("R8 control write ignored", irq_wake, 1);
        step(10);
        rst_n = 1'b1;
        step(1);
        pulse_clr();
        chk("R8 clear after release", tmr_flag, 0);
    endtask

    task automatic t_clock_src();
        realtime t1, t2;
        xtal_is_cpu = 1'b1;
        wr(1'b1, 16'h0007);
        wr(1'b0, 16'd0);
        chk("R7 crystal refused", clk_src_xtal, 0);
        @(posedge tmr_flag); t1 = $realtime;
        @(negedge cpu_clk); pulse_clr();
        @(posedge tmr_flag); t2 = $realtime;
        chk("R7 forced cpu period ns", int'(t2 - t1), 640);
        @(negedge xtal_clk); #1;
        xtal_is_cpu = 1'b0;
        #1;
        chk("R7 crystal selected", clk_src_xtal, 1);
        flag_clr = 1'b1; #25; flag_clr = 1'b0;
        @(posedge tmr_flag); t1 = $realtime;
        #1; flag_clr = 1'b1; #25; flag_clr = 1'b0;
        @(posedge tmr_flag); t2 = $realtime;
        chk("R7 crystal period ns", int'(t2 - t1), 2560);
    endtask

    initial begin
        repeat (100000) @(posedge cpu_clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge cpu_clk);
        t_reset();
        t_prescale();
        t_terminal();
        t_set_wins();
        t_irq();
        t_hold();
        t_ordinary_reset();
        t_clock_src();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule